// File: doc/BRIEF.md
# Transmit Sample Queue with Run Control

This block is the transmit-side word store of a serial audio port. A register-side writer pushes 32-bit sample words into a 128-entry queue, and a downstream frame shifter pulls them out one word per request. Software controls the queue through a two-bit operation register. A flush bit empties the queue and holds it empty. A run bit allows words to reach the shifter. Before use the queue is flushed, released and then started. Writing zero to the operation register pauses delivery and keeps whatever is stored.

A configuration word selects how many low bits of each entry the shifter consumes (8, 16 or 32) and sets a fill threshold. A status word reports the fill level together with full and empty flags. Three interrupt sources are recorded in a sticky status vector, and each can only be set while its enable bit is on: fill at or below threshold, queue empty, and a shifter request that found the queue empty while running. Status bits are cleared by writing ones.

Top module: `aud_txq`

## Requirements
- R1: After reset the status word reads 0x100 (level 0, empty set, full clear). The interrupt status is zero, `irq_o` is low, `pop_valid` is low, the width code is 2 and the threshold is DEPTH/2.
- R2: While operation bit 0 (flush) is set, the fill level is forced to zero within one cycle and pushes are discarded.
- R3: While operation bit 1 (run) is clear, a pop request returns no word (`pop_valid` low) and leaves the level unchanged.
- R4: While running and non-empty, a pop request yields `pop_valid` high one cycle later with the oldest stored word. Words leave in the order they were pushed.
- R5: Width code in configuration bits [1:0]: 0 delivers bits [7:0] zero-extended, 1 delivers bits [15:0], 2 and 3 deliver all 32 bits. Each entry occupies one slot whatever the width.
- R6: A push while the queue holds DEPTH words is dropped without altering the level or the stored words.
- R7: The status word carries the level modulo DEPTH in bits [6:0], full (level equal to DEPTH) in bit 7 and empty in bit 8.
- R8: Writing 0 to the operation register stops delivery but keeps the stored words. Setting run again resumes with the next unread word.
- R9: Interrupt status bit 9 is set when the fill level is at or below the threshold (configuration bits [8:2]) and enable bit 9 is on.
- R10: Interrupt status bit 7 is set when the queue is empty and enable bit 7 is on.
- R11: A pop request while running and empty sets interrupt status bit 3 if enable bit 3 is on. It delivers no word, and `pop_data` stays zero.
- R12: Writing a one to an interrupt status bit clears it unless its set condition holds in the same cycle. No bit sets while its enable is off. `irq_o` is high when any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_we | input | 1 | Operation register write strobe |
| op_wdata | input | 2 | Operation value: bit 0 flush, bit 1 run |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Bits [1:0] width code, bits [8:2] threshold |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 10 | Interrupt enable mask |
| clr_we | input | 1 | Interrupt status clear strobe |
| clr_wdata | input | 10 | Ones clear the matching status bits |
| push_en | input | 1 | Push one word |
| push_data | input | 32 | Word to push |
| pop_req | input | 1 | Shifter word request |
| pop_valid | output | 1 | A word was delivered for the previous request |
| pop_data | output | 32 | Delivered word, width-masked; zero when not valid |
| fifo_stat | output | 9 | Level, full and empty |
| irq_status | output | 10 | Sticky interrupt status |
| irq_o | output | 1 | OR of the interrupt status |

## Verification
The bench builds the block at its default parameters: 128 entries of 32 bits, with the threshold reset to 64. At this depth the status level field wraps to zero exactly when full is set. This makes the full-versus-level encoding observable, and 130 pushes reach the overflow drop. The 64 default threshold lets one pop from 65 stored words show the transition into the threshold interrupt.

// File: rtl/aud_txq_pkg.sv
package aud_txq_pkg;
   typedef enum logic [1:0] {
      WC_BYTE = 2'd0,
      WC_HALF = 2'd1,
      WC_WORD = 2'd2,
      WC_WIDE = 2'd3
   } wcode_e;

   localparam int IRQ_W     = 10;
   localparam int IRQ_UFLOW = 3;
   localparam int IRQ_EMPTY = 7;
   localparam int IRQ_THR   = 9;
endpackage

// File: rtl/aud_txq_store.sv
module aud_txq_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 128,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  cnt,
   output logic              rd_acc
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              wr_acc;

   assign wr_acc  = wr_req && !flush && (cnt != CNT_FULL);
   assign rd_acc  = rd_req && !flush && (cnt != '0);
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_acc) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (wr_acc) wr_ptr <= wr_ptr + 1'b1;
         if (rd_acc) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_acc, rd_acc})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/aud_txq_irq.sv
module aud_txq_irq #(
   parameter int IRQ_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] event_i,
   input  logic [IRQ_W-1:0] enable_i,
   input  logic             clr_we,
   input  logic [IRQ_W-1:0] clr_mask,
   output logic [IRQ_W-1:0] status_o
);
   for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (event_i[b] && enable_i[b])
            bit_q <= 1'b1;
         else if (clr_we && clr_mask[b])
            bit_q <= 1'b0;
      end
      assign status_o[b] = bit_q;
   end
endmodule

// File: rtl/aud_txq.sv
module aud_txq
   import aud_txq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 128,
   localparam int LVL_W  = $clog2(DEPTH),
   localparam int CNT_W  = LVL_W + 1,
   localparam int CFG_W  = LVL_W + 2,
   localparam int STAT_W = LVL_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_we,
   input  logic [1:0]        op_wdata,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              ien_we,
   input  logic [IRQ_W-1:0]  ien_wdata,
   input  logic              clr_we,
   input  logic [IRQ_W-1:0]  clr_wdata,
   input  logic              push_en,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_req,
   output logic              pop_valid,
   output logic [DATA_W-1:0] pop_data,
   output logic [STAT_W-1:0] fifo_stat,
   output logic [IRQ_W-1:0]  irq_status,
   output logic              irq_o
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("aud_txq: DEPTH must be a power of two of at least 4");
   end
   if (DATA_W < 16) begin : g_bad_width
      $error("aud_txq: DATA_W must be at least 16");
   end

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [1:0]        op_q;
   wcode_e            wc_q;
   logic [LVL_W-1:0]  thr_q;
   logic [IRQ_W-1:0]  ien_q;
   logic              flush, run;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] head;
   logic [DATA_W-1:0] head_masked;
   logic              rd_acc;
   logic [IRQ_W-1:0]  events;

   assign flush = op_q[0];
   assign run   = op_q[1] && !op_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= 2'b00;
         wc_q  <= WC_WORD;
         thr_q <= LVL_W'(DEPTH / 2);
         ien_q <= '0;
      end else begin
         if (op_we)  op_q <= op_wdata;
         if (cfg_we) begin
            wc_q  <= wcode_e'(cfg_wdata[1:0]);
            thr_q <= cfg_wdata[CFG_W-1:2];
         end
         if (ien_we) ien_q <= ien_wdata;
      end
   end

   aud_txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_req  (push_en),
      .wr_data (push_data),
      .rd_req  (pop_req && run),
      .rd_data (head),
      .cnt     (cnt),
      .rd_acc  (rd_acc)
   );

   always_comb begin
      case (wc_q)
         WC_BYTE: head_masked = {{(DATA_W-8){1'b0}},  head[7:0]};
         WC_HALF: head_masked = {{(DATA_W-16){1'b0}}, head[15:0]};
         default: head_masked = head;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_valid <= 1'b0;
         pop_data  <= '0;
      end else begin
         pop_valid <= rd_acc;
         pop_data  <= rd_acc ? head_masked : '0;
      end
   end

   always_comb begin
      events            = '0;
      events[IRQ_UFLOW] = pop_req && run && (cnt == '0);
      events[IRQ_EMPTY] = (cnt == '0);
      events[IRQ_THR]   = (cnt <= {1'b0, thr_q});
   end

   aud_txq_irq #(.IRQ_W(IRQ_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_i  (events),
      .enable_i (ien_q),
      .clr_we   (clr_we),
      .clr_mask (clr_wdata),
      .status_o (irq_status)
   );

   assign fifo_stat = {(cnt == '0), (cnt == CNT_FULL), cnt[LVL_W-1:0]};
   assign irq_o     = |irq_status;
endmodule

// File: rtl/aud_txq_chk.sv
module aud_txq_chk #(
   parameter int LVL_W  = 7,
   parameter int IRQ_W  = 10,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        op_q,
   input logic [LVL_W+1:0]  fifo_stat,
   input logic              pop_valid,
   input logic [DATA_W-1:0] pop_data,
   input logic [IRQ_W-1:0]  irq_status,
   input logic [IRQ_W-1:0]  ien_q
);
   // R2
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_q[0] |=> fifo_stat[LVL_W+1]);

   // R3
   idle_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_q[1] |=> !pop_valid);

   // R11
   zero_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_valid |-> pop_data == '0);

   // R6
   full_encoding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_stat[LVL_W] |-> (!fifo_stat[LVL_W+1] && fifo_stat[LVL_W-1:0] == '0));

   // R4
   pop_from_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> !$past(fifo_stat[LVL_W+1]));

   for (genvar b = 0; b < IRQ_W; b++) begin : g_mask
      // R12
      masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_status[b]) |-> $past(ien_q[b]));
   end
endmodule

bind aud_txq aud_txq_chk #(.LVL_W(LVL_W), .IRQ_W(IRQ_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_q       (op_q),
   .fifo_stat  (fifo_stat),
   .pop_valid  (pop_valid),
   .pop_data   (pop_data),
   .irq_status (irq_status),
   .ien_q      (ien_q)
);

// File: tb/aud_txq_tb.sv
module aud_txq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_we = 1'b0;
   logic [1:0]  op_wdata = '0;
   logic        cfg_we = 1'b0;
   logic [8:0]  cfg_wdata = '0;
   logic        ien_we = 1'b0;
   logic [9:0]  ien_wdata = '0;
   logic        clr_we = 1'b0;
   logic [9:0]  clr_wdata = '0;
   logic        push_en = 1'b0;
   logic [31:0] push_data = '0;
   logic        pop_req = 1'b0;
   logic        pop_valid;
   logic [31:0] pop_data;
   logic [8:0]  fifo_stat;
   logic [9:0]  irq_status;
   logic        irq_o;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   aud_txq u_dut (
      .clk(clk), .rst_n(rst_n),
      .op_we(op_we), .op_wdata(op_wdata),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .ien_we(ien_we), .ien_wdata(ien_wdata),
      .clr_we(clr_we), .clr_wdata(clr_wdata),
      .push_en(push_en), .push_data(push_data),
      .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
      .fifo_stat(fifo_stat), .irq_status(irq_status), .irq_o(irq_o)
   );

   // {width code, pushed word, expected delivered word}
   localparam logic [65:0] VECS [6] = '{
      {2'd2, 32'hA5C3_1E77, 32'hA5C3_1E77},
      {2'd0, 32'hA5C3_1E77, 32'h0000_0077},
      {2'd1, 32'hA5C3_1E77, 32'h0000_1E77},
      {2'd3, 32'h8001_7FFE, 32'h8001_7FFE},
      {2'd0, 32'h0000_01FF, 32'h0000_00FF},
      {2'd1, 32'hFFFF_0000, 32'h0000_0000}
   };

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic op_write(input logic [1:0] v);
      @(negedge clk); op_we = 1'b1; op_wdata = v;
      @(negedge clk); op_we = 1'b0;
   endtask

   task automatic cfg_write(input logic [6:0] thr, input logic [1:0] wc);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = {thr, wc};
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic ien_write(input logic [9:0] v);
      @(negedge clk); ien_we = 1'b1; ien_wdata = v;
      @(negedge clk); ien_we = 1'b0;
   endtask

   task automatic clr_write(input logic [9:0] v);
      @(negedge clk); clr_we = 1'b1; clr_wdata = v;
      @(negedge clk); clr_we = 1'b0;
   endtask

   task automatic push(input logic [31:0] w);
      @(negedge clk); push_en = 1'b1; push_data = w;
      @(negedge clk); push_en = 1'b0;
   endtask

   // result is registered at the edge between the two negedges
   task automatic pop();
      @(negedge clk); pop_req = 1'b1;
      @(negedge clk); pop_req = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk(fifo_stat == 9'h100, "R1 status", fifo_stat, 9'h100);
      chk(irq_status == '0 && !irq_o, "R1 irq", irq_status, 0);
      chk(!pop_valid, "R1 pop_valid", pop_valid, 0);

      // R2 flush holds empty and drops pushes
      push(32'h1);
      op_write(2'b01);
      idle(1);
      chk(fifo_stat == 9'h100, "R2 flushed", fifo_stat, 9'h100);
      push(32'h2);
      chk(fifo_stat == 9'h100, "R2 push dropped", fifo_stat, 9'h100);
      op_write(2'b00);
      op_write(2'b10);

      // R4 R5 table of widths
      for (int i = 0; i < 6; i++) begin
         cfg_write(7'd64, VECS[i][65:64]);
         push(VECS[i][63:32]);
         pop();
         chk(pop_valid && pop_data == VECS[i][31:0], "R5 width", pop_data, VECS[i][31:0]);
      end
      cfg_write(7'd64, 2'd2);

      // R4 R7 ordering and level
      push(32'hA0); push(32'hA1); push(32'hA2);
      chk(fifo_stat == 9'h003, "R7 level 3", fifo_stat, 9'h003);
      for (int i = 0; i < 3; i++) begin
         pop();
         chk(pop_valid && pop_data == 32'hA0 + i, "R4 order", pop_data, 32'hA0 + i);
      end

      // R3 R8 stop keeps contents
      push(32'hB0); push(32'hB1);
      pop();
      chk(pop_data == 32'hB0, "R8 first", pop_data, 32'hB0);
      op_write(2'b00);
      pop();
      chk(!pop_valid, "R3 no delivery when stopped", pop_valid, 0);
      chk(fifo_stat == 9'h001, "R8 level kept", fifo_stat, 9'h001);
      op_write(2'b10);
      pop();
      chk(pop_valid && pop_data == 32'hB1, "R8 resume", pop_data, 32'hB1);

      // R11 underflow
      ien_write(10'h008);
      clr_write(10'h3FF);
      pop();
      chk(!pop_valid && pop_data == 0, "R11 no word", pop_data, 0);
      chk(irq_status == 10'h008 && irq_o, "R11 underflow flag", irq_status, 10'h008);
      // R12 clear and mask
      clr_write(10'h008);
      chk(irq_status == 10'h000, "R12 w1c", irq_status, 0);
      ien_write(10'h000);
      pop();
      idle(1);
      chk(irq_status == 10'h000 && !irq_o, "R12 masked", irq_status, 0);

      // R10 empty flag
      ien_write(10'h080);
      idle(1);
      chk(irq_status[7], "R10 empty set", irq_status, 10'h080);
      push(32'hC0);
      clr_write(10'h080);
      chk(irq_status == 10'h000, "R10 cleared when not empty", irq_status, 0);
      pop();
      idle(1);
      chk(irq_status == 10'h080, "R10 empty again", irq_status, 10'h080);

      // R9 threshold
      ien_write(10'h000);
      op_write(2'b01);
      op_write(2'b00);
      for (int i = 0; i < 65; i++) push(32'h500 + i);
      ien_write(10'h200);
      clr_write(10'h3FF);
      idle(2);
      chk(irq_status == 10'h000, "R9 above threshold", irq_status, 0);
      op_write(2'b10);
      pop();
      idle(2);
      chk(irq_status == 10'h200, "R9 at threshold", irq_status, 10'h200);

      // R6 full and dropped push
      ien_write(10'h000);
      op_write(2'b01);
      op_write(2'b00);
      for (int i = 0; i < 130; i++) push(32'h1000 + i);
      chk(fifo_stat == 9'h080, "R6 full status", fifo_stat, 9'h080);
      op_write(2'b10);
      pop();
      chk(pop_data == 32'h1000, "R6 oldest intact", pop_data, 32'h1000);
      chk(fifo_stat == 9'h07F, "R7 level 127", fifo_stat, 9'h07F);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule